// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the active-low reset of a processor from two sources: a supply-good flag from an external threshold comparator, and an active-low manual reset line from a push-button. Reset is held low while either source is active. Once both have released, reset stays low for a timeout chosen by a 2-bit select input, and only then goes high.

Both inputs are asynchronous. Each passes through a two-flop synchronizer. The manual input must stay low for a minimum number of consecutive clock cycles before it counts, so short negative glitches and contact bounce are rejected. The timeout and the debounce length are cycle counts derived from a clock-frequency parameter, `CLK_KHZ`. If a source becomes active again during a timeout, the count restarts after the last release. The select input is read only when a timeout begins.

Top module: `sprv_rst_gen`

## Requirements
- R1: While `supply_ok_i` is low, `rst_no` is low. A supply drop during any state drives `rst_no` low within 4 clock edges.
- R2: A manual press that is held (`mr_ni` low) for at least the debounce length drives `rst_no` low, and `rst_no` stays low while the press is held.
- R3: When `supply_ok_i` rises and the manual input is inactive, `rst_no` stays low for exactly T+2 clock edges and goes high at edge T+3. T is the selected timeout in cycles.
- R4: When `mr_ni` returns high and the supply is good, `rst_no` stays low for exactly T+3 clock edges and goes high at edge T+4.
- R5: A low pulse on `mr_ni` that lasts fewer than DEB_CYC consecutive clock cycles is ignored and leaves `rst_no` high. A pulse of DEB_CYC cycles asserts reset. DEB_CYC = max(2, DEB_US*CLK_KHZ/1000).
- R6: The timeout select encodes T = ms*CLK_KHZ, with ms of 1, 20, 140 and 1120 for `tsel_i` = 0, 1, 2 and 3.
- R7: If either source becomes active again during a timeout, reset stays low and the full timeout restarts from the last release.
- R8: `tsel_i` is sampled only when a timeout starts. A change in the middle of a timeout does not alter its length.
- R9: While `rst_ni` is low, and after it rises until the first timeout completes, `rst_no` is low. `rst_no` is never unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| supply_ok_i | input | 1 | Supply-above-threshold flag, asynchronous |
| mr_ni | input | 1 | Manual reset request, active low, asynchronous |
| tsel_i | input | 2 | Timeout select |
| rst_no | output | 1 | Processor reset, active low, always driven |

## Verification
The assertions assume that `tsel_i` is a known value whenever a timeout is loaded. They also assume that the supply and manual inputs carry no unknown values after reset, because the synchronizers pass any X straight through. The bench changes each input only on the falling clock edge, and it holds `tsel_i` at a defined code at all times. Glitch widths and press lengths are whole clock cycles, which places the debounce boundary at an exact cycle count.

// File: rtl/sprv_pkg.sv
package sprv_pkg;
  localparam int unsigned TSEL_W = 2;
  typedef logic [TSEL_W-1:0] tsel_t;

  function automatic int unsigned tmo_ms(tsel_t s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 20;
      2'd2:    return 140;
      default: return 1120;
    endcase
  endfunction

  function automatic int unsigned tmo_cycles(tsel_t s, int unsigned clk_khz);
    return tmo_ms(s) * clk_khz;
  endfunction
endpackage

// File: rtl/sprv_sync.sv
module sprv_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/sprv_mr_filter.sv
module sprv_mr_filter #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_n_i,
  output logic act_o
);
  localparam int unsigned CW = (DEB_CYC > 2) ? $clog2(DEB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_o <= 1'b0;
    end else if (mr_n_i) begin
      cnt_q <= '0;
      act_o <= 1'b0;
    end else if (!act_o) begin
      if (cnt_q == LAST) act_o <= 1'b1;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sprv_timer.sv
module sprv_timer
  import sprv_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned CNT_W   = $clog2(tmo_cycles(2'd3, CLK_KHZ) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_active_i,
  input  tsel_t            tsel_i,
  output logic             rst_no,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, rst_q;

  // pend_q: a source was active, so the next idle cycle loads a fresh timeout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      rst_q  <= 1'b0;
    end else if (src_active_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      rst_q  <= 1'b0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      cnt_q  <= CNT_W'(tmo_cycles(tsel_i, CLK_KHZ) - 1);
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end else begin
      rst_q  <= 1'b1;
    end
  end

  assign rst_no = rst_q;
  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sprv_rst_gen.sv
module sprv_rst_gen
  import sprv_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned DEB_US  = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       mr_ni,
  input  logic [1:0] tsel_i,
  output logic       rst_no
);
  localparam int unsigned DEB_RAW = DEB_US * CLK_KHZ / 1000;
  localparam int unsigned DEB_CYC = (DEB_RAW < 2) ? 2 : DEB_RAW;
  localparam int unsigned CNT_W   = $clog2(tmo_cycles(2'd3, CLK_KHZ) + 1);

  logic [1:0]       sync_q;
  logic             sup_ok, mr_sync, mr_act, src_active, tmr_pend;
  logic [CNT_W-1:0] tmr_cnt;

  // bit1 = manual (idle high), bit0 = supply (assume bad at reset)
  sprv_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mr_ni, supply_ok_i}),
    .q_o    (sync_q)
  );

  assign sup_ok  = sync_q[0];
  assign mr_sync = sync_q[1];

  sprv_mr_filter #(.DEB_CYC(DEB_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mr_n_i (mr_sync),
    .act_o  (mr_act)
  );

  assign src_active = ~sup_ok | mr_act;

  sprv_timer #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_active_i (src_active),
    .tsel_i       (tsel_t'(tsel_i)),
    .rst_no       (rst_no),
    .cnt_o        (tmr_cnt),
    .pend_o       (tmr_pend)
  );
endmodule

// File: rtl/sprv_rst_gen_chk.sv
module sprv_rst_gen_chk
  import sprv_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned CNT_W   = 27
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_no,
  input logic             src_active,
  input logic             tmr_pend,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             mr_act,
  input logic             mr_sync,
  input logic [1:0]       tsel_i
);
  assert_src_holds_rst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_active |=> !rst_no);

  assert_count_holds_rst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_cnt != '0) |-> !rst_no);

  assert_countdown_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_cnt != '0 && !src_active && !tmr_pend) |=> tmr_cnt == $past(tmr_cnt) - CNT_W'(1));

  assert_rise_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(tmr_cnt == '0 && !src_active && !tmr_pend));

  assert_mr_needs_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mr_act) |-> $past(!mr_sync));

  assert_load_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_pend && !src_active) |=>
      tmr_cnt == CNT_W'(tmo_cycles(tsel_t'($past(tsel_i)), CLK_KHZ) - 1));

  assert_known_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(rst_no));

  always_comb begin
    if (!rst_ni) assert_in_reset_R9: assert (rst_no == 1'b0 || $isunknown(rst_no));
  end
endmodule

bind sprv_rst_gen sprv_rst_gen_chk #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_no     (rst_no),
  .src_active (src_active),
  .tmr_pend   (tmr_pend),
  .tmr_cnt    (tmr_cnt),
  .mr_act     (mr_act),
  .mr_sync    (mr_sync),
  .tsel_i     (tsel_i)
);

// File: tb/tb_sprv_rst_gen.sv
module tb_sprv_rst_gen;
  localparam int unsigned KHZ = 10;
  localparam int DEB = 4;     // 400 us * 10 kHz / 1000
  localparam int LAT_SUP = 3; // supply release to reset high: T + 3 edges
  localparam int LAT_MR  = 4; // manual release to reset high: T + 4 edges

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok_i = 1'b0;
  logic mr_ni = 1'b1;
  logic [1:0] tsel_i = 2'd0;
  logic rst_no;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sprv_rst_gen #(.CLK_KHZ(KHZ), .DEB_US(400)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
    .mr_ni(mr_ni), .tsel_i(tsel_i), .rst_no(rst_no)
  );

  function automatic int exp_t(int s);
    case (s)
      0: return 10;
      1: return 200;
      2: return 1400;
      default: return 11200;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // after an input change just made, expect rise exactly at edge e
  task automatic expect_rise(int e, string req);
    cyc(e - 1);
    chk(rst_no === 1'b0, req, int'(rst_no), 0);
    cyc(1);
    chk(rst_no === 1'b1, req, int'(rst_no), 1);
  endtask

  task automatic t_reset();
    cyc(3);
    chk(rst_no === 1'b0, "R9 in reset", int'(rst_no), 0);
    rst_ni = 1'b1;
    cyc(30);
    chk(rst_no === 1'b0, "R1 supply low after reset", int'(rst_no), 0);
  endtask

  task automatic t_powerup();
    tsel_i = 2'd0;
    supply_ok_i = 1'b1;
    expect_rise(exp_t(0) + LAT_SUP, "R3 power-up timeout");
  endtask

  task automatic t_selects();
    for (int s = 0; s < 4; s++) begin
      tsel_i = 2'(s);
      supply_ok_i = 1'b0;
      cyc(4);
      chk(rst_no === 1'b0, "R1 supply drop", int'(rst_no), 0);
      cyc(3);
      supply_ok_i = 1'b1;
      expect_rise(exp_t(s) + LAT_SUP, "R6 select timeout");
    end
  endtask

  task automatic t_manual();
    tsel_i = 2'd0;
    mr_ni = 1'b0;
    cyc(25);
    chk(rst_no === 1'b0, "R2 manual held", int'(rst_no), 0);
    mr_ni = 1'b1;
    expect_rise(exp_t(0) + LAT_MR, "R4 manual release timeout");
  endtask

  task automatic t_glitch();
    bit seen_low = 1'b0;
    tsel_i = 2'd0;
    mr_ni = 1'b0;
    cyc(DEB - 1);
    mr_ni = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (rst_no !== 1'b1) seen_low = 1'b1;
    end
    chk(!seen_low, "R5 short pulse ignored", int'(seen_low), 0);
    mr_ni = 1'b0;
    cyc(DEB);
    mr_ni = 1'b1;
    seen_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      if (rst_no === 1'b0) seen_low = 1'b1;
    end
    chk(seen_low, "R5 minimum pulse asserts", int'(seen_low), 1);
    cyc(40);
    chk(rst_no === 1'b1, "R4 recovery after pulse", int'(rst_no), 1);
  endtask

  task automatic t_retrigger();
    tsel_i = 2'd1;
    supply_ok_i = 1'b0;
    cyc(6);
    supply_ok_i = 1'b1;
    cyc(100);
    mr_ni = 1'b0;
    cyc(10);
    mr_ni = 1'b1;
    expect_rise(exp_t(1) + LAT_MR, "R7 timeout restarts after re-press");
  endtask

  task automatic t_sel_change();
    tsel_i = 2'd1;
    supply_ok_i = 1'b0;
    cyc(6);
    supply_ok_i = 1'b1;
    cyc(8);
    tsel_i = 2'd0;
    cyc(100);
    chk(rst_no === 1'b0, "R8 mid-timeout select change", int'(rst_no), 0);
    expect_rise(exp_t(1) + LAT_SUP - 108, "R8 original length kept");
  endtask

  task automatic t_both();
    tsel_i = 2'd0;
    supply_ok_i = 1'b0;
    mr_ni = 1'b0;
    cyc(10);
    mr_ni = 1'b1;
    cyc(30);
    chk(rst_no === 1'b0, "R1 supply still low after manual release", int'(rst_no), 0);
    supply_ok_i = 1'b1;
    expect_rise(exp_t(0) + LAT_SUP, "R7 timeout from last release");
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_selects();
    t_manual();
    t_glitch();
    t_retrigger();
    t_sel_change();
    t_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule